// File: doc/BRIEF.md
# Crossbar Port Message Engine

This block is the per-port state machine of a small message-passing crossbar. It reads 33-bit entries from its input FIFO: 32 data bits and one framing bit. The framing bit is set on the first word (the header) and the last word (the tail) of every message. When a header is at the head of the FIFO, the block decodes the destination port and the command. It then raises a request to an external permission unit and moves words to the chosen output FIFO for as long as the permit stays high.

A unicast command sends the whole message to one output. A broadcast command copies each word to every port except the block's own, in ascending port order, and only then takes the next word from the input. When the permit drops, the transfer freezes, including the position inside the broadcast copy loop. It continues from that same point when the permit returns. A one-cycle done pulse tells the permission unit that the tail word has gone out.

Top module: `xbar_port_engine`

## Requirements
- R1: While reset is held and just after it is released, `req`, `out_wr`, `in_pop` and `msg_done` are all low.
- R2: An idle engine treats a non-empty head entry with framing bit (bit 32) = 1 and bit 0 = 1 as a header. It then raises `req` in the following cycle, with `req_dst` = header bits 4:1 and `req_bcast` = 1 exactly when header bits 12:9 equal 1.
- R3: No output is written while `permit` is low. A transfer that is paused by `permit` resumes later without losing or repeating any word.
- R4: For a unicast message, every word from header to tail reaches output `req_dst` in input order, and no other output receives a word.
- R5: For a broadcast message, each word is written to every port except `SELF_PORT`, in ascending port order. Port `SELF_PORT` never receives a word.
- R6: An output whose `out_full` is high is never written. The head word stays in the input FIFO until it can be delivered.
- R7: An input word is popped only in the cycle in which its last required copy is written. A broadcast word therefore leaves the input only after all other ports have taken it.
- R8: `msg_done` is high for exactly one cycle per message, in the cycle in which the tail is written. `req` is low in the next cycle.
- R9: An idle engine pops and discards a head entry that is not a header. It writes no output and raises no request.
- R10: Command values other than 1 are treated as unicast.
- R11: Only a word that follows the header and has both framing bit = 1 and bit 0 = 1 ends a message. A payload word with bit 0 = 1 and framing bit = 0 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 33 | Head entry of the input FIFO (bit 32 = framing bit) |
| in_empty | input | 1 | Input FIFO is empty |
| in_pop | output | 1 | Remove the head entry of the input FIFO |
| req | output | 1 | Request to the permission unit |
| req_dst | output | 4 | Destination decoded from the header |
| req_bcast | output | 1 | Current message is a broadcast |
| permit | input | 1 | Permission to transfer in this cycle |
| out_data | output | 33 | Word offered to the output FIFOs |
| out_wr | output | N_PORTS | One-hot write strobe to the output FIFOs |
| out_full | input | N_PORTS | Output FIFO full flags |
| msg_done | output | 1 | Tail word accepted in this cycle |

## Verification
The bench pulls the permit away in the middle of a broadcast copy loop. A design that restarted the loop would duplicate copies, and one that skipped ahead would drop them. It holds one output full while a message is pending. A design that ignored the flag would lose the word, and one that popped early would lose it from the input. It sends a payload word whose bit 0 is set without the framing bit, which would cut the message short in a design that decoded the tail loosely. It also sends a stray non-header word, which would hang an engine that waited for a header behind it. Unknown command values must route as unicast rather than fan out.

// File: rtl/xbar_port_pkg.sv
package xbar_port_pkg;
  localparam int WORD_W   = 33;
  localparam int FRAME_BIT = 32;
  localparam int DST_LSB  = 1;
  localparam int DST_W    = 4;
  localparam int CMD_LSB  = 9;
  localparam int CMD_W    = 4;
  localparam logic [CMD_W-1:0] CMD_FANOUT = 4'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MOVE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/xbar_hdr_decode.sv
module xbar_hdr_decode
  import xbar_port_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              is_mark,
  output logic [DST_W-1:0]  dst,
  output logic              fanout
);
  // header and tail share the same marking: framing bit plus bit 0
  assign is_mark = word[FRAME_BIT] & word[0];
  assign dst     = word[DST_LSB +: DST_W];
  assign fanout  = (word[CMD_LSB +: CMD_W] == CMD_FANOUT);
endmodule

// File: rtl/xbar_fanout_cursor.sv
module xbar_fanout_cursor #(
  parameter int N_PORTS   = 4,
  parameter int SELF_PORT = 0,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          adv,
  output logic [PW-1:0] idx,
  output logic          last
);
  localparam int FIRST_T = (SELF_PORT == 0) ? 1 : 0;
  localparam int LAST_T  = (SELF_PORT == N_PORTS-1) ? N_PORTS-2 : N_PORTS-1;

  logic [PW-1:0] idx_d;
  logic          idx_en;
  logic [PW:0]   step1;
  logic [PW:0]   step2;

  always_comb begin
    step1 = {1'b0, idx} + 1'b1;
    step2 = (step1 == (PW+1)'(SELF_PORT)) ? step1 + 1'b1 : step1;
    idx_en = restart | adv;
    idx_d  = restart ? PW'(FIRST_T) : step2[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= PW'(FIRST_T);
    else if (idx_en) idx <= idx_d;
  end

  assign last = (idx == PW'(LAST_T));
endmodule

// File: rtl/xbar_port_engine.sv
module xbar_port_engine
  import xbar_port_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int SELF_PORT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   in_word,
  input  logic                in_empty,
  output logic                in_pop,
  output logic                req,
  output logic [DST_W-1:0]    req_dst,
  output logic                req_bcast,
  input  logic                permit,
  output logic [WORD_W-1:0]   out_data,
  output logic [N_PORTS-1:0]  out_wr,
  input  logic [N_PORTS-1:0]  out_full,
  output logic                msg_done
);
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam logic [N_PORTS-1:0] ONE_HOT0 = N_PORTS'(1);

  eng_state_e         state_q, state_d;
  logic [DST_W-1:0]   dst_q;
  logic               fan_q;
  logic               first_q, first_d, first_en;
  logic               hdr_take;

  logic               hd_mark;
  logic [DST_W-1:0]   hd_dst;
  logic               hd_fan;
  logic [PW-1:0]      cur_idx;
  logic               cur_last;
  logic               cur_restart, cur_adv;

  logic [DST_W-1:0]   tgt;
  logic [N_PORTS-1:0] tgt_oh;
  logic               tgt_full, moving, accept, last_copy;

  xbar_hdr_decode u_dec (
    .word    (in_word),
    .is_mark (hd_mark),
    .dst     (hd_dst),
    .fanout  (hd_fan)
  );

  xbar_fanout_cursor #(.N_PORTS(N_PORTS), .SELF_PORT(SELF_PORT)) u_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cur_restart),
    .adv     (cur_adv),
    .idx     (cur_idx),
    .last    (cur_last)
  );

  // datapath selection for the current copy
  always_comb begin
    tgt       = fan_q ? DST_W'(cur_idx) : dst_q;
    tgt_oh    = ONE_HOT0 << tgt;
    tgt_full  = |(out_full & tgt_oh);
    moving    = (state_q == ST_MOVE) && permit && !in_empty;
    accept    = moving && !tgt_full;
    last_copy = !fan_q || cur_last;
  end

  // next state and strobes
  always_comb begin
    state_d     = state_q;
    hdr_take    = 1'b0;
    in_pop      = 1'b0;
    msg_done    = 1'b0;
    out_wr      = '0;
    first_en    = 1'b0;
    first_d     = first_q;
    cur_restart = 1'b0;
    cur_adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!in_empty) begin
          if (hd_mark) begin
            hdr_take    = 1'b1;
            first_en    = 1'b1;
            first_d     = 1'b1;
            cur_restart = 1'b1;
            state_d     = ST_WAIT;
          end else begin
            in_pop = 1'b1;            // stray word outside a message
          end
        end
      end
      ST_WAIT: begin
        if (permit) state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (!permit) begin
          state_d = ST_WAIT;
        end else if (accept) begin
          out_wr = tgt_oh;
          if (last_copy) begin
            in_pop      = 1'b1;
            cur_restart = fan_q;
            first_en    = 1'b1;
            first_d     = 1'b0;
            if (hd_mark && !first_q) begin
              msg_done = 1'b1;
              state_d  = ST_IDLE;
            end
          end else begin
            cur_adv = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      fan_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hdr_take) begin
        dst_q <= hd_dst;
        fan_q <= hd_fan;
      end
      if (first_en) first_q <= first_d;
    end
  end

  assign req       = (state_q != ST_IDLE);
  assign req_dst   = dst_q;
  assign req_bcast = fan_q;
  assign out_data  = in_word;
endmodule

// File: rtl/xbar_port_engine_chk.sv
module xbar_port_engine_chk #(
  parameter int N_PORTS   = 4,
  parameter int SELF_PORT = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [32:0]        in_word,
  input logic               in_empty,
  input logic               in_pop,
  input logic               req,
  input logic [3:0]         req_dst,
  input logic               req_bcast,
  input logic               permit,
  input logic [N_PORTS-1:0] out_wr,
  input logic [N_PORTS-1:0] out_full,
  input logic               msg_done
);
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!req && out_wr == '0 && !in_pop && !msg_done)
        else $error("reset outputs active");
    end
  end

  p_no_write_unpermitted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_wr) |-> (permit && req));

  p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_wr));

  p_dst_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && $past(req) && !$past(msg_done)) |-> $stable(req_dst));

  p_self_skipped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr[SELF_PORT] || !req_bcast);

  p_no_write_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr & out_full) == '0);

  p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> (!in_empty && ((|out_wr) || !req)));

  p_done_on_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> (in_pop && in_word[32] && in_word[0] && (|out_wr)));

  p_done_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> (!req && !msg_done));
endmodule

bind xbar_port_engine xbar_port_engine_chk #(.N_PORTS(N_PORTS), .SELF_PORT(SELF_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_empty(in_empty), .in_pop(in_pop),
  .req(req), .req_dst(req_dst), .req_bcast(req_bcast), .permit(permit),
  .out_wr(out_wr), .out_full(out_full), .msg_done(msg_done)
);

// File: tb/sim_xbar_port_engine.sv
`timescale 1ns/1ps
module sim_xbar_port_engine;
  localparam int NP   = 4;
  localparam int SELF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [32:0]   in_word;
  logic          in_empty, in_pop, req, req_bcast, permit, msg_done;
  logic [3:0]    req_dst;
  logic [32:0]   out_data;
  logic [NP-1:0] out_wr, out_full;

  xbar_port_engine #(.N_PORTS(NP), .SELF_PORT(SELF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_empty(in_empty), .in_pop(in_pop),
    .req(req), .req_dst(req_dst), .req_bcast(req_bcast), .permit(permit),
    .out_data(out_data), .out_wr(out_wr), .out_full(out_full), .msg_done(msg_done)
  );

  // input FIFO model
  logic [32:0] qmem [0:255];
  int wp = 0, rp = 0;
  assign in_empty = (rp == wp);
  assign in_word  = qmem[rp[7:0]];

  // output capture and event log
  logic [32:0] cap [0:NP-1][0:63];
  int ccnt [0:NP-1];
  int log_port [0:255];
  int log_pops [0:255];
  int nlog = 0, npops = 0, ndone = 0, cyc = 0;
  int nchk = 0, nfail = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (out_wr[p] && !out_full[p]) begin
          if (ccnt[p] < 64) cap[p][ccnt[p]] = out_data;
          ccnt[p]++;
          if (nlog < 256) begin
            log_port[nlog] = p;
            log_pops[nlog] = npops;
          end
          nlog++;
        end
      end
      if (in_pop) begin
        npops++;
        rp <= rp + 1;
      end
      if (msg_done) ndone++;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] mk_hdr(input int dst, input int cmd);
    return {1'b1, 5'd0, 10'd3, 4'd0, 4'(cmd), 4'd0, 4'(dst), 1'b1};
  endfunction
  function automatic logic [32:0] mk_tail(input int src, input int tag);
    return {1'b1, 12'd0, 11'(tag), 4'd0, 4'(src), 1'b1};
  endfunction

  task automatic push(input logic [32:0] w);
    qmem[wp[7:0]] = w;
    wp = wp + 1;
  endtask

  task automatic clear_caps();
    for (int p = 0; p < NP; p++) ccnt[p] = 0;
    nlog = 0;
  endtask

  task automatic wait_done(input int n);
    int t = 0;
    while (ndone < n && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check({req, out_wr, in_pop, msg_done} == '0, "R1 reset outputs",
          {req, out_wr, in_pop, msg_done}, 0);
  endtask

  task automatic t_unicast();
    logic [32:0] exp [0:3];
    int d0;
    exp[0] = mk_hdr(1, 0);
    exp[1] = {1'b0, 32'h0000_0011};   // bit0 set, framing clear: not a tail (R11)
    exp[2] = {1'b0, 32'h1234_5672};
    exp[3] = mk_tail(2, 77);
    clear_caps();
    d0 = ndone;
    permit = 1'b1;
    for (int i = 0; i < 4; i++) push(exp[i]);
    wait_done(d0 + 1);
    check(ccnt[1] == 4, "R4 R11 unicast word count", ccnt[1], 4);
    for (int i = 0; i < 4; i++)
      if (ccnt[1] > i) check(cap[1][i] == exp[i], "R4 unicast word", cap[1][i], exp[i]);
    check(ccnt[0] + ccnt[2] + ccnt[3] == 0, "R4 other outputs silent", ccnt[0] + ccnt[2] + ccnt[3], 0);
    idle(3);
    check(ndone == d0 + 1, "R8 one done pulse", ndone - d0, 1);
    check(!req, "R8 req released", req, 0);
  endtask

  task automatic t_decode_wait();
    int p0, d0;
    clear_caps();
    d0 = ndone;
    permit = 1'b0;
    push(mk_hdr(3, 0));
    p0 = npops;
    idle(4);
    check(req == 1'b1, "R2 req raised", req, 1);
    check(req_dst == 4'd3, "R2 destination", req_dst, 3);
    check(req_bcast == 1'b0, "R2 unicast flag", req_bcast, 0);
    check(nlog == 0 && npops == p0, "R3 nothing moves without permit", nlog, 0);
    push({1'b0, 32'hCAFE_0000});
    push(mk_tail(2, 5));
    permit = 1'b1;
    wait_done(d0 + 1);
    check(ccnt[3] == 3, "R3 transfer after permit", ccnt[3], 3);
  endtask

  task automatic t_bcast(input bit toggle);
    logic [32:0] exp [0:4];
    int d0, order_bad, pop_bad;
    int tgts [0:2];
    tgts[0] = 0; tgts[1] = 1; tgts[2] = 3;
    exp[0] = mk_hdr(0, 1);
    exp[1] = {1'b0, 32'hAAAA_0001};
    exp[2] = {1'b0, 32'h5555_0002};
    exp[3] = {1'b0, 32'h0F0F_0003};
    exp[4] = mk_tail(2, 9);
    clear_caps();
    d0 = ndone;
    permit = 1'b0;
    push(exp[0]);
    idle(3);
    check(req_bcast == 1'b1, "R2 broadcast flag", req_bcast, 1);
    for (int i = 1; i < 5; i++) push(exp[i]);
    if (!toggle) begin
      permit = 1'b1;
      wait_done(d0 + 1);
    end else begin
      int t = 0;
      while (ndone < d0 + 1 && t < 3000) begin
        permit = ((t % 5) < 2);
        @(negedge clk);
        t++;
      end
      permit = 1'b1;
    end
    for (int k = 0; k < 3; k++) begin
      int p = tgts[k];
      check(ccnt[p] == 5, toggle ? "R3 R5 paused copy count" : "R5 copy count", ccnt[p], 5);
      for (int i = 0; i < 5; i++)
        if (ccnt[p] > i && cap[p][i] != exp[i])
          check(1'b0, "R5 copy content", cap[p][i], exp[i]);
    end
    check(ccnt[SELF] == 0, "R5 own port skipped", ccnt[SELF], 0);
    order_bad = 0;
    pop_bad = 0;
    for (int k = 0; k < nlog && k < 256; k++) begin
      if (log_port[k] != tgts[k % 3]) order_bad++;
      if (log_pops[k] - log_pops[0] != k / 3) pop_bad++;
    end
    check(order_bad == 0, "R5 ascending copy order", order_bad, 0);
    check(pop_bad == 0, "R7 pop after last copy", pop_bad, 0);
  endtask

  task automatic t_full();
    int p0, d0;
    clear_caps();
    d0 = ndone;
    permit = 1'b1;
    out_full = 4'b0010;
    p0 = npops;
    push(mk_hdr(1, 0));
    push({1'b0, 32'h7777_0000});
    push(mk_tail(2, 1));
    idle(8);
    check(ccnt[1] == 0, "R6 no write to full output", ccnt[1], 0);
    check(npops == p0, "R6 head word kept", npops - p0, 0);
    out_full = '0;
    wait_done(d0 + 1);
    check(ccnt[1] == 3, "R6 delivered after release", ccnt[1], 3);
  endtask

  task automatic t_stray();
    int p0;
    clear_caps();
    permit = 1'b1;
    p0 = npops;
    push({1'b0, 32'hABCD_0001});
    idle(4);
    check(npops == p0 + 1, "R9 stray word popped", npops - p0, 1);
    check(nlog == 0, "R9 stray word not forwarded", nlog, 0);
    check(!req, "R9 no request", req, 0);
  endtask

  task automatic t_other_cmd();
    int d0;
    clear_caps();
    d0 = ndone;
    permit = 1'b1;
    push(mk_hdr(0, 5));
    push(mk_tail(2, 3));
    wait_done(d0 + 1);
    check(ccnt[0] == 2, "R10 unknown command unicast", ccnt[0], 2);
    check(ccnt[1] + ccnt[3] == 0, "R10 no fan-out", ccnt[1] + ccnt[3], 0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) ccnt[p] = 0;
    permit = 1'b0;
    out_full = '0;
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_unicast();
    t_decode_wait();
    t_bcast(1'b0);
    t_bcast(1'b1);
    t_full();
    t_stray();
    t_other_cmd();
    idle(3);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule